// File: doc/BRIEF.md
# Accumulator Processor with Shared Program and Data Memory

This block is a small multi-cycle processor with one accumulator. Program words and data words sit in the same external memory and travel over the same address and data lines. Every memory access is staged through two internal registers: an address-holding register drives the memory address port, and a data-holding register captures read data or supplies write data. A sequencer performs exactly one register transfer per clock. It runs a fixed four-step instruction fetch and then an execute sequence chosen by the opcode.

The memory port is synchronous. The block presents an address, and the read word comes back one clock later. A write happens on the clock edge where the write enable is high. A debug view of the program counter, the instruction register and the accumulator is always driven, together with a flag that shows the processor has stopped. The surrounding logic loads a program into memory, releases reset, and waits for the stop flag.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, the program counter, instruction register and accumulator read 0, the stopped flag is low, and the write enable is low.
- R2: The fetch runs in four single-transfer cycles: the address register takes the program counter, the program counter adds 1 (modulo 256), the data register takes the memory word, and the instruction register takes the data register. The first fetch reads address 0, and the fetched word appears on the debug instruction output after the fourth clock edge.
- R3: An instruction word is 16 bits. Bits [15:8] hold the opcode and bits [7:0] hold the operand address. On the clock after the decode cycle, an operand-using instruction drives the operand address onto the memory address port.
- R4: Opcode 0x01 (load) sets the accumulator to the memory word at the operand address. The accumulator changes only in the final cycle of a load, add or subtract.
- R5: Opcode 0x02 (add) sets the accumulator to accumulator plus the memory word, modulo 2^16.
- R6: Opcode 0x03 (subtract) sets the accumulator to accumulator minus the memory word, modulo 2^16.
- R7: Opcode 0x04 (store) writes the accumulator to the operand address with a write enable that is high for exactly one clock. No other opcode ever writes memory.
- R8: Opcode 0x05 (jump) sets the program counter to the operand address, and the next fetch reads from there.
- R9: Opcode 0xFF (stop) raises the stopped flag. From then on, the program counter, instruction register and accumulator hold their values and memory is not written until reset.
- R10: Any other opcode is a no-op. It changes nothing except the program counter increment of its fetch.
- R11: The program counter wraps from 255 to 0, so the word after address 255 is fetched from address 0.
- R12: An instruction takes 8 clocks for load, add or subtract, 7 for store, and 5 for jump, no-op or stop (counted until the stopped flag is visible).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_wdata | output | 16 | Memory write data, driven by the data register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| halted | output | 1 | Processor has executed a stop instruction |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |

## Verification
A wrong sequencer state or a bad staging register shows at the ports within one or two clocks. It appears as a memory address that is not the program counter or the operand field, as a write pulse that is too long or carries data other than the accumulator, or as a fetched word that never reaches the instruction output. Errors in the arithmetic or in instruction length show up later: in the stored result word, in the final program counter, and in the clock count until the stopped flag. Each short program is therefore judged by its memory contents, its register values and its exact duration. Self-modifying and wrap-around programs confirm that code and data really share one address space.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Sequencer states: one register transfer each
  typedef enum logic [3:0] {
    S_F_MAR, S_F_INC, S_F_MBR, S_F_IR, S_DEC,
    S_X_WAIT, S_X_RD, S_X_ALU, S_X_ST1, S_X_ST2, S_HALT
  } cpu_state_e;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h02;
  localparam logic [7:0] OPC_SUB   = 8'h03;
  localparam logic [7:0] OPC_STORE = 8'h04;
  localparam logic [7:0] OPC_JUMP  = 8'h05;
  localparam logic [7:0] OPC_STOP  = 8'hFF;

  typedef enum logic [2:0] {
    CL_MEMRD, CL_STORE, CL_JUMP, CL_STOP, CL_NOP
  } op_class_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB
  } alu_op_e;

  // Register-transfer strobes, at most one active per cycle
  typedef struct packed {
    logic ld_mar_pc;
    logic inc_pc;
    logic ld_mbr_mem;
    logic ld_ir;
    logic ld_mar_ir;
    logic ld_pc_ir;
    logic ld_acc;
    logic ld_mbr_acc;
    logic mem_we;
  } ctl_t;

  function automatic op_class_e op_class(input logic [7:0] opc);
    case (opc)
      OPC_LOAD, OPC_ADD, OPC_SUB: op_class = CL_MEMRD;
      OPC_STORE:                  op_class = CL_STORE;
      OPC_JUMP:                   op_class = CL_JUMP;
      OPC_STOP:                   op_class = CL_STOP;
      default:                    op_class = CL_NOP;
    endcase
  endfunction

  function automatic alu_op_e alu_sel(input logic [7:0] opc);
    case (opc)
      OPC_ADD: alu_sel = ALU_ADD;
      OPC_SUB: alu_sel = ALU_SUB;
      default: alu_sel = ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  function automatic logic [W-1:0] alu_eval(input alu_op_e f,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] z);
    case (f)
      ALU_ADD: alu_eval = x + z;
      ALU_SUB: alu_eval = x - z;
      default: alu_eval = z;
    endcase
  endfunction

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opc,
  output cpu_state_e state,
  output ctl_t       ctl
);

  cpu_state_e state_q, state_d;
  op_class_e  cls;

  assign cls = op_class(opc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F_MAR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_F_MAR:  state_d = S_F_INC;
      S_F_INC:  state_d = S_F_MBR;
      S_F_MBR:  state_d = S_F_IR;
      S_F_IR:   state_d = S_DEC;
      S_DEC: begin
        case (cls)
          CL_MEMRD: state_d = S_X_WAIT;
          CL_STORE: state_d = S_X_ST1;
          CL_STOP:  state_d = S_HALT;
          default:  state_d = S_F_MAR;
        endcase
      end
      S_X_WAIT: state_d = S_X_RD;
      S_X_RD:   state_d = S_X_ALU;
      S_X_ALU:  state_d = S_F_MAR;
      S_X_ST1:  state_d = S_X_ST2;
      S_X_ST2:  state_d = S_F_MAR;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_F_MAR;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      S_F_MAR: ctl.ld_mar_pc  = 1'b1;
      S_F_INC: ctl.inc_pc     = 1'b1;
      S_F_MBR: ctl.ld_mbr_mem = 1'b1;
      S_F_IR:  ctl.ld_ir      = 1'b1;
      S_DEC: begin
        ctl.ld_mar_ir = (cls == CL_MEMRD) || (cls == CL_STORE);
        ctl.ld_pc_ir  = (cls == CL_JUMP);
      end
      S_X_RD:  ctl.ld_mbr_mem = 1'b1;
      S_X_ALU: ctl.ld_acc     = 1'b1;
      S_X_ST1: ctl.ld_mbr_acc = 1'b1;
      S_X_ST2: ctl.mem_we     = 1'b1;
      default: ctl = '0;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  alu_op_e           alu_op,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc
);

  logic [DATA_W-1:0] alu_y;
  logic [ADDR_W-1:0] ir_addr;

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    pc_step = p + 1'b1;
  endfunction

  assign ir_addr = ir[ADDR_W-1:0];

  acc_cpu_alu #(.W(DATA_W)) alu_i (
    .op (alu_op),
    .a  (acc),
    .b  (mbr),
    .y  (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ctl.inc_pc)          pc  <= pc_step(pc);
      else if (ctl.ld_pc_ir)   pc  <= ir_addr;
      if (ctl.ld_mar_pc)       mar <= pc;
      else if (ctl.ld_mar_ir)  mar <= ir_addr;
      if (ctl.ld_mbr_mem)      mbr <= mem_rdata;
      else if (ctl.ld_mbr_acc) mbr <= acc;
      if (ctl.ld_ir)           ir  <= mbr;
      if (ctl.ld_acc)          acc <= alu_y;
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_acc
);

  localparam int OP_W = DATA_W - ADDR_W;

  cpu_state_e        state_w;
  ctl_t              ctl_w;
  logic [7:0]        opc_w;
  alu_op_e           alu_op_w;
  logic [ADDR_W-1:0] pc_w, mar_w;
  logic [DATA_W-1:0] mbr_w, ir_w, acc_w;

  assign opc_w    = 8'(ir_w[DATA_W-1 -: OP_W]);
  assign alu_op_w = alu_sel(opc_w);

  acc_cpu_seq seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .opc   (opc_w),
    .state (state_w),
    .ctl   (ctl_w)
  );

  acc_cpu_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl_w),
    .alu_op    (alu_op_w),
    .mem_rdata (mem_rdata),
    .pc        (pc_w),
    .mar       (mar_w),
    .mbr       (mbr_w),
    .ir        (ir_w),
    .acc       (acc_w)
  );

  assign mem_addr  = mar_w;
  assign mem_wdata = mbr_w;
  assign mem_we    = ctl_w.mem_we;
  assign halted    = (state_w == S_HALT);
  assign dbg_pc    = pc_w;
  assign dbg_ir    = ir_w;
  assign dbg_acc   = acc_w;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input ctl_t              ctl,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              halted,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_ir,
  input logic [DATA_W-1:0] dbg_acc
);

  logic [ADDR_W-1:0] pc_plus1;
  assign pc_plus1 = dbg_pc + 1'b1;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (dbg_pc == '0 && dbg_acc == '0 && dbg_ir == '0 && !halted));

  assert_one_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl));

  assert_mar_from_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_mar_pc |=> mem_addr == $past(dbg_pc));

  assert_pc_incr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.inc_pc |=> dbg_pc == $past(pc_plus1));

  assert_operand_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_mar_ir |=> mem_addr == $past(dbg_ir[ADDR_W-1:0]));

  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld_acc |=> $stable(dbg_acc));

  assert_store_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == dbg_acc);

  assert_store_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_pc_ir |=> dbg_pc == $past(dbg_ir[ADDR_W-1:0]));

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(dbg_pc) &&
                $stable(dbg_ir) && $stable(dbg_acc)));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl       (ctl_w),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .halted    (halted),
  .dbg_pc    (dbg_pc),
  .dbg_ir    (dbg_ir),
  .dbg_acc   (dbg_acc)
);

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = '0;
  logic        halted;
  logic [7:0]  dbg_pc;
  logic [15:0] dbg_ir;
  logic [15:0] dbg_acc;

  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  int wr_cnt;

  always #2.5 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_acc(dbg_acc)
  );

  // Synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst_n)      wr_cnt <= 0;
    else if (mem_we) wr_cnt <= wr_cnt + 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // op, operand A (loaded first), operand B
  localparam logic [39:0] VEC [6] = '{
    40'h02_1234_0101,
    40'h02_FFFF_0002,
    40'h03_0005_0007,
    40'h03_8000_0001,
    40'h01_1111_BEEF,
    40'h7E_AAAA_5555
  };

  function automatic logic [15:0] instr(input logic [7:0] op, input logic [7:0] a);
    instr = {op, a};
  endfunction

  function automatic logic [15:0] ref_op(input logic [7:0] op,
                                         input logic [15:0] a, input logic [15:0] b);
    case (op)
      8'h01:   ref_op = b;
      8'h02:   ref_op = 16'((32'(a) + 32'(b)) % 65536);
      8'h03:   ref_op = 16'((32'(a) + 65536 - 32'(b)) % 65536);
      default: ref_op = a;
    endcase
  endfunction

  function automatic int ref_len(input logic [7:0] op);
    ref_len = (op >= 8'h01 && op <= 8'h03) ? 8 : 5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_stop(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) break;
    end
  endtask

  initial begin
    int n;
    logic [15:0] sum;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 pc", 32'(dbg_pc), 0);
    chk("R1 ir", 32'(dbg_ir), 0);
    chk("R1 acc", 32'(dbg_acc), 0);
    chk("R1 halted/we", {halted, mem_we}, 0);

    // Vector table: LOAD 40, <op> 41, STORE 42, STOP
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  op;
      logic [15:0] a, b, expv;
      {op, a, b} = VEC[v];
      expv = ref_op(op, a, b);
      do_reset();
      mem[0] = instr(8'h01, 8'h40);
      mem[1] = instr(op, 8'h41);
      mem[2] = instr(8'h04, 8'h42);
      mem[3] = instr(8'hFF, 8'h00);
      mem[8'h40] = a;
      mem[8'h41] = b;
      release_rst();
      run_to_stop(n);
      chk($sformatf("R5/R6/R4/R10 vec%0d acc", v), 32'(dbg_acc), 32'(expv));
      chk($sformatf("R7 vec%0d stored", v), 32'(mem[8'h42]), 32'(expv));
      chk($sformatf("R10 vec%0d operand kept", v), 32'(mem[8'h41]), 32'(b));
      chk($sformatf("R12 vec%0d cycles", v), n, 8 + ref_len(op) + 7 + 5);
      chk($sformatf("R7 vec%0d writes", v), wr_cnt, 1);
      chk($sformatf("R9 vec%0d pc", v), 32'(dbg_pc), 4);
    end

    // R2 / R3 fetch stepping
    do_reset();
    mem[0] = instr(8'h01, 8'h40);
    mem[8'h40] = 16'h5A5A;
    release_rst();
    @(posedge clk); @(negedge clk);
    chk("R2 first fetch addr", 32'(mem_addr), 0);
    chk("R2 pc before inc", 32'(dbg_pc), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 pc after inc", 32'(dbg_pc), 1);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    chk("R2 ir loaded", 32'(dbg_ir), 32'(instr(8'h01, 8'h40)));
    @(posedge clk); @(negedge clk);
    chk("R3 operand addr", 32'(mem_addr), 32'h40);
    chk("R4 acc not yet", 32'(dbg_acc), 0);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R4 load result", 32'(dbg_acc), 32'h5A5A);

    // Summation program
    do_reset();
    mem[0] = instr(8'h01, 8'h80);
    mem[1] = instr(8'h02, 8'h81);
    mem[2] = instr(8'h02, 8'h82);
    mem[3] = instr(8'h02, 8'h83);
    mem[4] = instr(8'h04, 8'h90);
    mem[5] = instr(8'hFF, 8'h00);
    mem[8'h80] = 16'h4000; mem[8'h81] = 16'h3000;
    mem[8'h82] = 16'h9000; mem[8'h83] = 16'h0123;
    sum = '0;
    for (int i = 0; i < 4; i++) sum = ref_op(8'h02, sum, mem[8'h80 + i]);
    release_rst();
    run_to_stop(n);
    chk("R5 sum stored", 32'(mem[8'h90]), 32'(sum));
    chk("R9 sum final pc", 32'(dbg_pc), 6);
    chk("R12 sum cycles", n, 4 * 8 + 7 + 5);

    // R8 jump
    do_reset();
    mem[0] = instr(8'h05, 8'h10);
    mem[1] = instr(8'h04, 8'h60);
    mem[8'h10] = instr(8'h01, 8'h50);
    mem[8'h11] = instr(8'h04, 8'h51);
    mem[8'h12] = instr(8'hFF, 8'h00);
    mem[8'h50] = 16'hC0DE;
    release_rst();
    run_to_stop(n);
    chk("R8 jump target executed", 32'(mem[8'h51]), 32'hC0DE);
    chk("R8 skipped store", 32'(mem[8'h60]), 0);
    chk("R8 final pc", 32'(dbg_pc), 32'h13);
    chk("R12 jump cycles", n, 5 + 8 + 7 + 5);

    // R11 wrap with self-modifying code
    do_reset();
    mem[0] = instr(8'h01, 8'h30);
    mem[1] = instr(8'h04, 8'h00);
    mem[2] = instr(8'h05, 8'hFF);
    mem[8'hFF] = instr(8'h02, 8'h31);
    mem[8'h30] = 16'hFF00;
    mem[8'h31] = 16'h0001;
    release_rst();
    run_to_stop(n);
    chk("R11 wrapped pc", 32'(dbg_pc), 1);
    chk("R11 acc", 32'(dbg_acc), 32'hFF01);
    chk("R3 stop word in ir", 32'(dbg_ir), 32'hFF00);
    chk("R12 wrap cycles", n, 8 + 7 + 5 + 8 + 5);

    // R9 hold after stop
    repeat (20) begin @(posedge clk); @(negedge clk); end
    chk("R9 halted held", 32'(halted), 1);
    chk("R9 pc held", 32'(dbg_pc), 1);
    chk("R9 acc held", 32'(dbg_acc), 32'hFF01);
    chk("R9 no writes", wr_cnt, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule